// File: doc/BRIEF.md
# Serial-Input Latched Sink Driver Core

This block is the digital core of a serial-loaded power driver with a parameterized number of channels (eight by default). Control data arrives one bit at a time on a serial data pin and is clocked into a shift register on the rising edges of a serial clock. The last register stage is brought out as a serial output. Wiring that output to the data input of a second driver chains the two devices into one longer register.

A strobe input copies the register into a bank of data latches. The latches stay transparent for as long as the strobe is high and hold their contents once it goes low. An active-low output enable passes the latch bank onto the sink-control outputs. A 1 turns a sink on. When the enable is inactive, every sink is forced off and the stored data is left alone.

The block runs from one system clock. The serial clock is treated as a sampled input, and its rising transitions are found by edge detection. The latches are registers that reload on every system clock cycle while the strobe is high. The reset is asserted asynchronously and released synchronously.

Top module: `serial_sink_driver`

## Requirements
- R1: While reset is asserted, and right after it is released, the shift register and the latches are all zero, so `ser_out` is 0 and every `sink_on` bit is 0.
- R2: On the system clock edge that first samples `shift_clk` high after a low sample, stage 0 takes `ser_in` and each stage k (k ≥ 1) takes the old value of stage k-1. The new contents are visible after that edge.
- R3: `ser_out` always presents the last stage (stage W-1). A bit entered on the data input appears on `ser_out` after W shifts, which allows daisy-chaining.
- R4: On every system clock edge where `strobe` is sampled high, each latch takes the value its shift stage held before that edge. Channel i is loaded from stage i.
- R5: When `strobe` is sampled low, the latches keep their contents, even while shifting goes on.
- R6: While `drv_en_n` is 1, every `sink_on` bit is 0 in the same cycle, and the latch and shift contents are not changed.
- R7: While `drv_en_n` is 0, `sink_on[i]` equals latch i in the same cycle. A value of 1 means the sink is on.
- R8: Without a new rising `shift_clk` transition the shift register does not change, whatever `ser_in` does. This holds whether `shift_clk` is held high or held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| shift_clk | input | 1 | Serial clock; a rising transition shifts in one bit |
| ser_in | input | 1 | Serial data input |
| strobe | input | 1 | Latch transparency control, active high |
| drv_en_n | input | 1 | Output enable, active low |
| ser_out | output | 1 | Last shift stage, used for cascading |
| sink_on | output | W | Sink drive controls; 1 = sink on |

## Verification
A shift takes effect on the system clock edge that samples the rising `shift_clk`. A rising serial clock therefore costs two system cycles: one with the clock high and one with it low. A latch load is due one edge after a high `strobe` is sampled, and it captures the pre-edge register. The enable gating on `sink_on` takes effect in the same cycle, with no register in its path. The bench changes all inputs on the falling system clock edge and updates its reference model once per rising edge. It compares `ser_out` and `sink_on` at the following falling edge, so every check samples after exactly the number of registers each result passes through.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  parameter int unsigned SSD_DEF_CHANNELS = 8;
  parameter int unsigned SSD_SYNC_STAGES  = 2;
endpackage

// File: rtl/ssd_rst_sync.sv
module ssd_rst_sync #(
  parameter int unsigned STAGES = ssd_pkg::SSD_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ok = chain_q[STAGES-1];
endmodule

// File: rtl/ssd_edge_det.sv
module ssd_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic prev_q;

  // reset to 1 so a clock already high at release is not taken as an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/ssd_shift.sv
module ssd_shift #(
  parameter int unsigned W = ssd_pkg::SSD_DEF_CHANNELS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] stages
);
  logic [W-1:0] stages_q;
  logic [W-1:0] stages_d;

  for (genvar k = 0; k < W; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_comb stages_d[k] = step ? din : stages_q[k];
    end else begin : g_body
      always_comb stages_d[k] = step ? stages_q[k-1] : stages_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stages_q <= '0;
    else        stages_q <= stages_d;
  end

  assign stages = stages_q;
endmodule

// File: rtl/ssd_latch_bank.sv
module ssd_latch_bank #(
  parameter int unsigned W = ssd_pkg::SSD_DEF_CHANNELS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] src,
  output logic [W-1:0] held
);
  logic [W-1:0] held_q;
  logic [W-1:0] held_d;

  for (genvar i = 0; i < W; i++) begin : g_cell
    always_comb held_d[i] = load ? src[i] : held_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign held = held_q;
endmodule

// File: rtl/serial_sink_driver.sv
module serial_sink_driver #(
  parameter int unsigned W = ssd_pkg::SSD_DEF_CHANNELS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_clk,
  input  logic         ser_in,
  input  logic         strobe,
  input  logic         drv_en_n,
  output logic         ser_out,
  output logic [W-1:0] sink_on
);
  logic         rst_ok;
  logic         step;
  logic [W-1:0] sr_q;
  logic [W-1:0] lat_q;

  ssd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ok(rst_ok));

  ssd_edge_det u_edge (.clk(clk), .rst_n(rst_ok), .level(shift_clk), .rise(step));

  ssd_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_ok), .step(step), .din(ser_in), .stages(sr_q)
  );

  ssd_latch_bank #(.W(W)) u_lat (
    .clk(clk), .rst_n(rst_ok), .load(strobe), .src(sr_q), .held(lat_q)
  );

  assign ser_out = sr_q[W-1];

  for (genvar i = 0; i < W; i++) begin : g_out
    assign sink_on[i] = lat_q[i] & ~drv_en_n;
  end
endmodule

// File: rtl/ssd_checker.sv
module ssd_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rst_ok,
  input logic         step,
  input logic         ser_in,
  input logic         strobe,
  input logic         drv_en_n,
  input logic [W-1:0] sr,
  input logic [W-1:0] lat,
  input logic         ser_out,
  input logic [W-1:0] sink_on
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (sr == '0 && lat == '0 && sink_on == '0));

  assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    step |=> sr == {$past(sr[W-2:0]), $past(ser_in)});

  assert_last_stage_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    step |=> ser_out == $past(sr[W-2]));

  assert_latch_follow_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    strobe |=> lat == $past(sr));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    !strobe |=> $stable(lat));

  assert_blank_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    drv_en_n |-> sink_on == '0);

  assert_drive_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    !drv_en_n |-> sink_on == lat);

  assert_no_edge_hold_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    !step |=> $stable(sr));
endmodule

bind serial_sink_driver ssd_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_ok(rst_ok), .step(step), .ser_in(ser_in),
  .strobe(strobe), .drv_en_n(drv_en_n), .sr(sr_q), .lat(lat_q),
  .ser_out(ser_out), .sink_on(sink_on)
);

// File: tb/serial_sink_driver_test.sv
module serial_sink_driver_test;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst_n, shift_clk, ser_in, strobe, drv_en_n;
  logic         ser_out;
  logic [W-1:0] sink_on;

  int unsigned checks = 0;
  int unsigned fails  = 0;
  int unsigned cycles = 0;
  bit          done   = 0;

  // reference model state
  logic [W-1:0] m_sr, m_lat;
  logic         m_prev;

  always #2 clk = ~clk;

  serial_sink_driver #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .ser_in(ser_in),
    .strobe(strobe), .drv_en_n(drv_en_n), .ser_out(ser_out), .sink_on(sink_on)
  );

  function automatic logic [W-1:0] exp_drive(input logic [W-1:0] l, input logic en_n);
    return en_n ? '0 : l;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // called at a falling edge: apply inputs, step model on rising edge, check at next falling edge
  task automatic tick(input logic s, input logic d, input logic st, input logic en_n,
                      input string tag);
    logic rise;
    shift_clk = s; ser_in = d; strobe = st; drv_en_n = en_n;
    @(posedge clk);
    rise   = s & ~m_prev;
    m_prev = s;
    if (st) m_lat = m_sr;
    if (rise) m_sr = {m_sr[W-2:0], d};
    @(negedge clk);
    check(ser_out === m_sr[W-1], {tag, " ser_out R3"}, {{(W-1){1'b0}}, ser_out},
          {{(W-1){1'b0}}, m_sr[W-1]});
    check(sink_on === exp_drive(m_lat, en_n), {tag, " sink_on R7 R6"}, sink_on,
          exp_drive(m_lat, en_n));
  endtask

  task automatic shift_bit(input logic d, input logic st, input logic en_n, input string tag);
    tick(1'b1, d, st, en_n, tag);
    tick(1'b0, d, st, en_n, tag);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin : main
    logic [W-1:0] pat;
    logic [W-1:0] snap;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; shift_clk = 1'b0; ser_in = 1'b0; strobe = 1'b0; drv_en_n = 1'b0;
    m_sr = '0; m_lat = '0; m_prev = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sink_on === '0, "R1 sink_on in reset", sink_on, '0);
    check(ser_out === 1'b0, "R1 ser_out in reset", {{(W-1){1'b0}}, ser_out}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_prev = 1'b0;
    check(sink_on === '0, "R1 sink_on after release", sink_on, '0);

    // R2 R5: load a pattern with strobe low; outputs must stay off
    pat = 8'b1011_0010;
    for (int i = W - 1; i >= 0; i--) shift_bit(pat[i], 1'b0, 1'b0, "R2 R5 load");
    check(sink_on === '0, "R5 latches held during load", sink_on, '0);
    // R4: one strobe cycle transfers the register (stage i -> channel i)
    tick(1'b0, 1'b0, 1'b1, 1'b0, "R4 strobe");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "R4 after strobe");
    check(sink_on === pat, "R4 R7 pattern on sinks", sink_on, pat);

    // R8: shift_clk held high / low, data toggling: no change
    tick(1'b1, 1'b1, 1'b0, 1'b0, "R8 rise");
    snap = m_sr;
    for (int i = 0; i < 10; i++) tick(1'b1, i[0], 1'b1, 1'b0, "R8 held high");
    for (int i = 0; i < 10; i++) tick(1'b0, i[0], 1'b1, 1'b0, "R8 held low");
    check(sink_on === snap, "R8 register unchanged", sink_on, snap);

    // R3: cascade - first bits of pattern leave on ser_out in order
    pat = 8'b1100_1010;
    for (int i = W - 1; i >= 0; i--) shift_bit(pat[i], 1'b0, 1'b0, "R3 fill");
    for (int i = W - 1; i >= 0; i--) begin
      check(ser_out === pat[i], "R3 cascade order", {{(W-1){1'b0}}, ser_out},
            {{(W-1){1'b0}}, pat[i]});
      shift_bit(1'b0, 1'b0, 1'b0, "R3 drain");
    end

    // R6: transparent latches with enable off during entry
    for (int i = 0; i < W; i++) shift_bit(i[0] ^ i[1], 1'b1, 1'b1, "R6 bypass entry");
    check(sink_on === '0, "R6 blanked", sink_on, '0);
    tick(1'b0, 1'b0, 1'b0, 1'b0, "R6 enable restores");
    check(sink_on === m_lat, "R6 R7 contents kept", sink_on, m_lat);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      tick(1'($urandom), 1'($urandom), ($urandom % 4) == 0, ($urandom % 5) == 0,
           "R2 R4 R5 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule